// File: doc/BRIEF.md
# Single-Dword Memory Read Requester

This block fetches one dword from host memory over a packet-based serial bus. Software first loads a 64-bit bus address, then pulses a start strobe. The block picks the header length from the address. It uses a three-dword header when the upper half of the address is zero and a four-dword header otherwise. It fills in the requester identity, a per-request tag, the length and the byte enables, and sends the header one dword at a time on a valid/ready stream.

The block then watches the incoming packet stream for a completion that carries its tag. A completion with data ends the request successfully and returns its first payload dword. A completion without data ends the request as an error and reports the three-bit completion status. The Unsupported Request code gets a flag of its own. Any packet that is not a matching completion is dropped, and the request stays outstanding.

Top module: `mrd_requester`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `done`, `err` and `ur` are 0, `cpl_status` is 0, and the first request uses tag 0.
- R2: When address bits 63:32 are all zero, the request is three dwords long: `32'h0000_0001` (read format 000, type 00000, every bit from 23 to 10 zero, length 1), then header dword 1, then the low address with bits 1:0 forced to 0.
- R3: When any of address bits 63:32 is set, the request is four dwords long: `32'h2000_0001` (format 001), then header dword 1, then address bits 63:32, then the low address with bits 1:0 forced to 0.
- R4: Header dword 1 holds the requester identity latched at start in bits 31:16, the tag in bits 15:8, the last-dword byte enable 0000 in bits 7:4 and the first-dword byte enable 1111 in bits 3:0.
- R5: `tx_valid` stays high and `tx_data`/`tx_last` stay unchanged while `tx_ready` is low. `tx_last` is high only on the final header dword, and `tx_valid` falls after that dword is accepted.
- R6: Each accepted start uses the tag one above the previous request's tag, wrapping from 255 to 0.
- R7: `busy` is high from the clock after an accepted start until the completion is taken. While `busy` is high, start strobes and address loads have no effect. An address load in the same cycle as a start is also ignored.
- R8: A completion is taken in the clock after its last beat. It must carry dword 0 bits 28:24 = 01010, dword 0 bits 31:29 = 010 (with data) or 000 (without data), and a tag in dword 2 bits 15:8 equal to the outstanding tag. Taking it raises `done` for exactly one cycle and clears `busy`.
- R9: A taken completion with data puts its dword 3 on `rd_data` with `err` = 0. A taken completion without data sets `err`, copies dword 1 bits 15:13 to `cpl_status`, and sets `ur` only when that status is 001. These results hold until the next accepted start, which clears `err`, `ur` and `cpl_status`.
- R10: An incoming packet with the wrong tag, a type other than 01010, or one that arrives when no request is waiting for a completion changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_we | input | 1 | Load `addr_wdata` into the address register |
| addr_wdata | input | 64 | Bus address of the dword to fetch |
| req_id | input | 16 | Requester identity, latched at start |
| start | input | 1 | Launch a request |
| tx_valid | output | 1 | Outgoing header dword is valid |
| tx_ready | input | 1 | Downstream accepts the current dword |
| tx_data | output | 32 | Outgoing header dword |
| tx_last | output | 1 | Final dword of the outgoing header |
| rx_valid | input | 1 | Incoming packet dword is valid |
| rx_data | input | 32 | Incoming packet dword |
| rx_last | input | 1 | Final dword of the incoming packet |
| busy | output | 1 | A request is outstanding |
| done | output | 1 | One-cycle pulse when a completion is taken |
| err | output | 1 | Last request ended with a completion without data |
| ur | output | 1 | That completion reported Unsupported Request |
| cpl_status | output | 3 | Status code of that completion |
| rd_data | output | 32 | Payload dword of the last successful completion |

## Verification
The hardest case to reach from the ports is a request that is still in flight while stray traffic arrives. The stray traffic includes a completion with a stale tag, a non-completion packet, a second start and an address load, all landing while the header is stalled or while a completion is awaited. The stimulus produces this with a pseudo-random `tx_ready` pattern and injected packets whose tags are computed from the bench's own tag count. Tag wrap is reached by running more than 256 back-to-back requests, alternating between short and long header formats.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
    localparam int DW_W      = 32;
    localparam int ADDR_W    = 64;
    localparam int RID_W     = 16;
    localparam int TAG_W     = 8;
    localparam int STAT_W    = 3;
    localparam int HDR_MAX   = 4;
    localparam int IDX_W     = $clog2(HDR_MAX);
    localparam int BEAT_W    = $clog2(HDR_MAX) + 1;

    localparam logic [2:0] FMT_HDR3_ND = 3'b000;
    localparam logic [2:0] FMT_HDR4_ND = 3'b001;
    localparam logic [2:0] FMT_HDR3_WD = 3'b010;
    localparam logic [4:0] TYP_MEM     = 5'b00000;
    localparam logic [4:0] TYP_CPL     = 5'b01010;
    localparam logic [STAT_W-1:0] STAT_UNSUP = 3'b001;
    localparam logic [3:0] BE_FIRST    = 4'b1111;
    localparam logic [3:0] BE_LAST     = 4'b0000;
    localparam logic [9:0] LEN_ONE     = 10'd1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [2:0]        fmt;
        logic [4:0]        typ;
        logic [STAT_W-1:0] status;
        logic [TAG_W-1:0]  tag;
        logic [DW_W-1:0]   payload;
    } cpl_evt_t;
endpackage

// File: rtl/mrd_hdr_build.sv
module mrd_hdr_build
    import mrd_pkg::*;
(
    input  logic [ADDR_W-1:0]           addr,
    input  logic [RID_W-1:0]            rid,
    input  logic [TAG_W-1:0]            tag,
    output logic [HDR_MAX-1:0][DW_W-1:0] hdr,
    output logic [IDX_W:0]              hdr_cnt
);
    localparam int HALF = ADDR_W / 2;

    logic            hi_zero;
    logic [DW_W-1:0] lo_dw;
    logic            unused_addr_bits;

    assign hi_zero          = (addr[ADDR_W-1:HALF] == '0);
    assign lo_dw            = {addr[HALF-1:2], 2'b00};
    assign unused_addr_bits = ^addr[1:0];

    always_comb begin
        hdr[0]  = {(hi_zero ? FMT_HDR3_ND : FMT_HDR4_ND), TYP_MEM, 14'd0, LEN_ONE};
        hdr[1]  = {rid, tag, BE_LAST, BE_FIRST};
        hdr[2]  = hi_zero ? lo_dw : addr[ADDR_W-1:HALF];
        hdr[3]  = hi_zero ? '0 : lo_dw;
        hdr_cnt = hi_zero ? (IDX_W+1)'(3) : (IDX_W+1)'(4);
    end
endmodule

// File: rtl/mrd_tx_stream.sv
module mrd_tx_stream
    import mrd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch,
    input  logic [HDR_MAX-1:0][DW_W-1:0] hdr,
    input  logic [IDX_W:0]               hdr_cnt,
    input  logic                         tx_ready,
    output logic                         tx_valid,
    output logic [DW_W-1:0]              tx_data,
    output logic                         tx_last,
    output logic                         sent
);
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } txs_t;

    txs_t s_d, s_q;
    logic at_end;

    assign at_end   = ({1'b0, s_q.idx} == hdr_cnt - 1'b1);
    assign tx_valid = s_q.active;
    assign tx_data  = hdr[s_q.idx];
    assign tx_last  = s_q.active && at_end;
    assign sent     = s_q.active && tx_ready && at_end;

    always_comb begin
        s_d = s_q;
        if (launch) begin
            s_d.active = 1'b1;
            s_d.idx    = '0;
        end else if (s_q.active && tx_ready) begin
            if (at_end) begin
                s_d.active = 1'b0;
                s_d.idx    = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
endmodule

// File: rtl/mrd_cpl_parse.sv
module mrd_cpl_parse
    import mrd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic [DW_W-1:0] rx_data,
    input  logic            rx_last,
    output cpl_evt_t        evt
);
    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic [2:0]        fmt;
        logic [4:0]        typ;
        logic [STAT_W-1:0] status;
        logic [TAG_W-1:0]  tag;
        logic [DW_W-1:0]   payload;
        cpl_evt_t          evt;
    } prs_t;

    prs_t p_d, p_q;
    logic [HDR_MAX-1:0] hit;
    logic [2:0]         cur_fmt;
    logic [4:0]         cur_typ;
    logic [STAT_W-1:0]  cur_status;
    logic [TAG_W-1:0]   cur_tag;
    logic [DW_W-1:0]    cur_payload;
    logic               unused_rx_bits;

    for (genvar gi = 0; gi < HDR_MAX; gi++) begin : g_hit
        assign hit[gi] = rx_valid && (p_q.beat == BEAT_W'(gi));
    end

    assign cur_fmt        = hit[0] ? rx_data[31:29] : p_q.fmt;
    assign cur_typ        = hit[0] ? rx_data[28:24] : p_q.typ;
    assign cur_status     = hit[1] ? rx_data[15:13] : p_q.status;
    assign cur_tag        = hit[2] ? rx_data[15:8]  : p_q.tag;
    assign cur_payload    = hit[3] ? rx_data        : p_q.payload;
    assign unused_rx_bits = ^{rx_data[23:16], rx_data[12:0]};

    always_comb begin
        p_d           = p_q;
        p_d.evt.valid = 1'b0;
        if (rx_valid) begin
            p_d.fmt     = cur_fmt;
            p_d.typ     = cur_typ;
            p_d.status  = cur_status;
            p_d.tag     = cur_tag;
            p_d.payload = cur_payload;
            if (rx_last) begin
                p_d.beat        = '0;
                p_d.evt.valid   = 1'b1;
                p_d.evt.fmt     = cur_fmt;
                p_d.evt.typ     = cur_typ;
                p_d.evt.status  = cur_status;
                p_d.evt.tag     = cur_tag;
                p_d.evt.payload = cur_payload;
            end else if (p_q.beat < BEAT_W'(HDR_MAX)) begin
                p_d.beat = p_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign evt = p_q.evt;

    assert_evt_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.valid |-> $past(rx_valid && rx_last));
endmodule

// File: rtl/mrd_requester.sv
module mrd_requester
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [63:0]       addr_wdata,
    input  logic [15:0]       req_id,
    input  logic              start,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [31:0]       rx_data,
    input  logic              rx_last,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ur,
    output logic [2:0]        cpl_status,
    output logic [31:0]       rd_data
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [RID_W-1:0]  rid;
        logic [TAG_W-1:0]  req_tag;
        logic [TAG_W-1:0]  next_tag;
        logic              done;
        logic              err;
        logic              ur;
        logic [STAT_W-1:0] status;
        logic [DW_W-1:0]   rdata;
    } top_t;

    top_t r_d, r_q;

    logic [HDR_MAX-1:0][DW_W-1:0] hdr;
    logic [IDX_W:0]               hdr_cnt;
    logic                         launch;
    logic                         sent;
    cpl_evt_t                     evt;
    logic                         evt_match;

    mrd_hdr_build u_hdr (
        .addr    (r_q.addr),
        .rid     (r_q.rid),
        .tag     (r_q.req_tag),
        .hdr     (hdr),
        .hdr_cnt (hdr_cnt)
    );

    mrd_tx_stream u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .hdr      (hdr),
        .hdr_cnt  (hdr_cnt),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .sent     (sent)
    );

    mrd_cpl_parse u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .evt      (evt)
    );

    assign launch    = (r_q.ph == PH_IDLE) && start;
    assign evt_match = evt.valid && (evt.typ == TYP_CPL) && (evt.tag == r_q.req_tag)
                     && ((evt.fmt == FMT_HDR3_WD) || (evt.fmt == FMT_HDR3_ND));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph       = PH_SEND;
                    r_d.rid      = req_id;
                    r_d.req_tag  = r_q.next_tag;
                    r_d.next_tag = r_q.next_tag + 1'b1;
                    r_d.err      = 1'b0;
                    r_d.ur       = 1'b0;
                    r_d.status   = '0;
                end else if (addr_we) begin
                    r_d.addr = addr_wdata;
                end
            end
            PH_SEND: begin
                if (sent) r_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (evt_match) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                    if (evt.fmt == FMT_HDR3_WD) begin
                        r_d.rdata = evt.payload;
                    end else begin
                        r_d.err    = 1'b1;
                        r_d.status = evt.status;
                        r_d.ur     = (evt.status == STAT_UNSUP);
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.ph != PH_IDLE);
    assign done       = r_q.done;
    assign err        = r_q.err;
    assign ur         = r_q.ur;
    assign cpl_status = r_q.status;
    assign rd_data    = r_q.rdata;

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.req_tag) && $stable(r_q.rid));

    assert_addr_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.addr));

    assert_tag_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (r_q.next_tag == r_q.req_tag + 1'b1));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_ur_needs_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ur |-> err);

    assert_no_send_while_waiting_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
endmodule

// File: tb/mrd_requester_tb.sv
module mrd_requester_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_we = 1'b0;
    logic [63:0] addr_wdata = '0;
    logic [15:0] req_id = 16'h0000;
    logic        start = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0;
    logic        busy, done, err, ur;
    logic [2:0]  cpl_status;
    logic [31:0] rd_data;

    always #4 clk = ~clk;

    mrd_requester u_dut (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .req_id(req_id), .start(start), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .busy(busy), .done(done), .err(err), .ur(ur),
        .cpl_status(cpl_status), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // reference model
    int          m_state = 0;
    logic [31:0] m_hdr[$];
    logic [63:0] m_addr = '0;
    int          m_next_tag = 0;
    int          m_tag = 0;
    bit          m_done = 0, m_err = 0, m_ur = 0;
    logic [2:0]  m_status = '0;
    logic [31:0] m_rdata = '0;
    logic [31:0] m_beats[4];
    int          m_cnt = 0;
    bit          m_ev = 0;
    logic [2:0]  m_ev_fmt;
    logic [4:0]  m_ev_typ;
    logic [2:0]  m_ev_st;
    logic [7:0]  m_ev_tag;
    logic [31:0] m_ev_pay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_hdr.delete(); m_addr = '0; m_next_tag = 0; m_tag = 0;
            m_done = 0; m_err = 0; m_ur = 0; m_status = '0; m_rdata = '0;
            m_cnt = 0; m_ev = 0;
            foreach (m_beats[i]) m_beats[i] = '0;
        end else begin
            m_done = 0;
            case (m_state)
                0: begin
                    if (start) begin
                        logic [31:0] lo;
                        lo = {m_addr[31:2], 2'b00};
                        m_tag = m_next_tag;
                        m_next_tag = (m_next_tag + 1) % 256;
                        m_hdr.delete();
                        if (m_addr[63:32] == 0) begin
                            m_hdr.push_back(32'h0000_0001);
                            m_hdr.push_back({req_id, 8'(m_tag), 8'h0F});
                            m_hdr.push_back(lo);
                        end else begin
                            m_hdr.push_back(32'h2000_0001);
                            m_hdr.push_back({req_id, 8'(m_tag), 8'h0F});
                            m_hdr.push_back(m_addr[63:32]);
                            m_hdr.push_back(lo);
                        end
                        m_err = 0; m_ur = 0; m_status = 0;
                        m_state = 1;
                    end else if (addr_we) begin
                        m_addr = addr_wdata;
                    end
                end
                1: begin
                    if (tx_ready) begin
                        void'(m_hdr.pop_front());
                        if (m_hdr.size() == 0) m_state = 2;
                    end
                end
                default: begin
                    if (m_ev && m_ev_typ == 5'b01010 && m_ev_tag == 8'(m_tag)
                        && (m_ev_fmt == 3'b010 || m_ev_fmt == 3'b000)) begin
                        m_state = 0;
                        m_done = 1;
                        if (m_ev_fmt == 3'b010) m_rdata = m_ev_pay;
                        else begin
                            m_err = 1; m_status = m_ev_st; m_ur = (m_ev_st == 3'b001);
                        end
                    end
                end
            endcase
            m_ev = 0;
            if (rx_valid) begin
                if (m_cnt < 4) m_beats[m_cnt] = rx_data;
                if (rx_last) begin
                    m_ev = 1;
                    m_ev_fmt = m_beats[0][31:29];
                    m_ev_typ = m_beats[0][28:24];
                    m_ev_st  = m_beats[1][15:13];
                    m_ev_tag = m_beats[2][15:8];
                    m_ev_pay = m_beats[3];
                    m_cnt = 0;
                end else if (m_cnt < 4) m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_state != 0), "R7 busy", 64'(busy), 64'(m_state != 0));
            chk(tx_valid == (m_state == 1), "R5 tx_valid", 64'(tx_valid), 64'(m_state == 1));
            if (m_state == 1 && m_hdr.size() > 0) begin
                chk(tx_data == m_hdr[0], "R2 R3 R4 R6 tx_data", 64'(tx_data), 64'(m_hdr[0]));
                chk(tx_last == (m_hdr.size() == 1), "R5 tx_last", 64'(tx_last), 64'(m_hdr.size() == 1));
            end
            chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
            chk(err == m_err, "R9 err", 64'(err), 64'(m_err));
            chk(ur == m_ur, "R9 ur", 64'(ur), 64'(m_ur));
            chk(cpl_status == m_status, "R9 cpl_status", 64'(cpl_status), 64'(m_status));
            chk(rd_data == m_rdata, "R9 rd_data", 64'(rd_data), 64'(m_rdata));
        end
    end

    // pseudo-random back-pressure
    bit         stall_en = 0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic load_addr(input logic [63:0] a);
        @(negedge clk); addr_we = 1'b1; addr_wdata = a;
        @(negedge clk); addr_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_tx_done();
        while (tx_valid) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [2:0] fmt, input logic [4:0] typ,
                            input logic [2:0] st, input logic [7:0] tag, input logic [31:0] pay);
        int n;
        n = (fmt == 3'b010) ? 4 : 3;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_last  = (i == n - 1);
            case (i)
                0: rx_data = {fmt, typ, 14'd0, (fmt == 3'b010) ? 10'd1 : 10'd0};
                1: rx_data = {16'hC0DE, st, 1'b0, 12'd4};
                2: rx_data = {16'h0100, tag, 8'h00};
                default: rx_data = pay;
            endcase
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (busy && guard < 50) begin @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !tx_valid && !done && !err && !ur && cpl_status == 0, "R1 reset outputs",
            64'({busy, tx_valid, done, err, ur, cpl_status}), 64'h0);
        rst_n = 1'b1;

        // short header, first tag 0, low bits of address masked
        req_id = 16'h0A01;
        load_addr(64'h0000_0000_1234_567B);
        pulse_start();
        chk(busy, "R7 busy after start", 64'(busy), 64'h1);
        chk(tx_data == 32'h0000_0001, "R2 dword0 short", 64'(tx_data), 64'h0000_0001);
        @(negedge clk);
        chk(tx_data == 32'h0A01_000F, "R1 R4 dword1 tag0", 64'(tx_data), 64'h0A01_000F);
        wait_tx_done();
        send_pkt(3'b010, 5'b01010, 3'b000, 8'd0, 32'hCAFE_F00D);
        wait_idle();
        chk(rd_data == 32'hCAFE_F00D && !err, "R8 R9 data completion", 64'(rd_data), 64'hCAFE_F00D);

        // long header with back-pressure and stray traffic
        stall_en = 1;
        req_id = 16'h0B02;
        load_addr(64'h0000_0001_8000_0013);
        pulse_start();
        chk(tx_data == 32'h2000_0001, "R3 dword0 long", 64'(tx_data), 64'h2000_0001);
        @(negedge clk); start = 1'b1; addr_we = 1'b1; addr_wdata = 64'h0;
        @(negedge clk); start = 1'b0; addr_we = 1'b0;
        wait_tx_done();
        send_pkt(3'b000, 5'b01010, 3'b001, 8'd7, 32'h0);
        repeat (3) @(negedge clk);
        chk(busy && !done && !err, "R10 wrong tag dropped", 64'({busy, done, err}), 64'b100);
        send_pkt(3'b010, 5'b00000, 3'b000, 8'd1, 32'h1111_2222);
        repeat (3) @(negedge clk);
        chk(busy && !done, "R10 non-completion dropped", 64'({busy, done}), 64'b10);
        send_pkt(3'b000, 5'b01010, 3'b001, 8'd1, 32'h0);
        wait_idle();
        chk(err && ur && cpl_status == 3'b001, "R9 unsupported request", 64'({err, ur, cpl_status}), 64'b11001);

        // completion arriving with nothing outstanding
        send_pkt(3'b010, 5'b01010, 3'b000, 8'd2, 32'hDEAD_0000);
        repeat (2) @(negedge clk);
        chk(rd_data == 32'hCAFE_F00D && !done, "R10 idle completion ignored", 64'(rd_data), 64'hCAFE_F00D);

        // tag 2: the ignored start did not consume a tag; status other than 001
        load_addr(64'h0000_0000_0000_0040);
        pulse_start();
        @(negedge clk);
        if (tx_valid && tx_data[31:16] == 16'h0B02)
            chk(tx_data[15:8] == 8'd2, "R6 R7 tag after ignored start", 64'(tx_data[15:8]), 64'd2);
        wait_tx_done();
        send_pkt(3'b000, 5'b01010, 3'b100, 8'd2, 32'h0);
        wait_idle();
        chk(err && !ur && cpl_status == 3'b100, "R9 abort status", 64'({err, ur, cpl_status}), 64'b10100);

        // many requests to wrap the tag
        for (int k = 0; k < 260; k++) begin
            stall_en = k[0];
            load_addr(k[1] ? {32'(k + 1), 32'(k * 16)} : {32'h0, 32'(k * 16 + 3)});
            pulse_start();
            wait_tx_done();
            send_pkt(3'b010, 5'b01010, 3'b000, 8'(m_tag), 32'(k * 7 + 5));
            wait_idle();
            chk(rd_data == 32'(k * 7 + 5), "R6 R8 wrap loop data", 64'(rd_data), 64'(k * 7 + 5));
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule